// File: doc/BRIEF.md
# Add/Subtract Arithmetic Unit with Condition Flags

This block is the arithmetic slice of a processor integer datapath. It takes two operands, an incoming carry flag and a 3-bit operation selector. It forms one of six functions: plain add, add with carry, subtract, subtract with carry, reverse subtract and reverse subtract with carry. It returns the result together with fresh negative, zero, carry and overflow flags. On subtraction the carry flag means "no borrow". A cleared carry-in on a carrying subtract therefore takes one extra unit away.

A flag-set input picks whether the instruction updates the flags. When it does not, the incoming flags pass straight back out and the flag write-enable output stays low. Selector values outside the six functions forward operand A unchanged and leave the flags alone. The datapath is purely combinational. A parameter places a register stage on all outputs, and that stage is on by default.

Top module: `addsub_flag_alu`

## Requirements
- R1: With op_sel = 3'b000 (add), result is (A + B) mod 2^32, and carry-out is 1 exactly when that result, read as unsigned, is below A.
- R2: With op_sel = 3'b001 (add with carry) and carry_in = 1, result is A + B + 1, and carry-out is 1 when the result is less than or equal to A unsigned. With carry_in = 0 it behaves as R1.
- R3: With op_sel = 3'b010 (subtract), result is A - B, and carry-out is 1 exactly when A >= B unsigned (no borrow).
- R4: With op_sel = 3'b011 (subtract with carry) and carry_in = 0, result is A - B - 1, and carry-out is 1 exactly when A > B unsigned. With carry_in = 1 it behaves as R3.
- R5: op_sel = 3'b100 and 3'b101 compute B - A and B - A - (1 - carry_in). They follow the rules of R3 and R4 with the roles of A and B exchanged.
- R6: Overflow is bit 31 of ~(A ^ B) & (A ^ result) for both add forms. For the subtract forms it is bit 31 of (M ^ S) & (M ^ result), where M is the minuend and S is the subtrahend.
- R7: flags_out is packed as {N, Z, C, V} from bit 3 down to bit 0. N is bit 31 of the result, and Z is 1 exactly when all result bits are zero.
- R8: op_sel = 3'b110 or 3'b111 returns A as the result, returns flags_in as flags_out, and drives flags_we to 0.
- R9: With set_flags = 0, flags_out equals flags_in and flags_we is 0, while the result is still computed. With set_flags = 1 and a valid op_sel, flags_we is 1.
- R10: With OUT_REG = 1, all outputs reflect the inputs present at the previous rising clock edge. A synchronous active-high reset clears result, flags_out and flags_we to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation selector |
| opnd_a | input | W | First operand (A) |
| opnd_b | input | W | Second operand (B) |
| carry_in | input | 1 | Current carry flag |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| set_flags | input | 1 | Instruction updates the flags |
| result | output | W | Arithmetic result |
| flags_out | output | 4 | New flags {N,Z,C,V} |
| flags_we | output | 1 | Flag write-enable |

## Verification
In a single cycle, the carry and overflow flags can both come from one arithmetic edge, and a zero result can coincide with both of them. Adding 0x80000000 to itself wraps the sum to zero, which raises C, V and Z together. The same operands with set_flags low must still give the zero result while the flags pass through unchanged. Each such case is compared in the cycle after it is applied, against values computed from unsigned and signed comparisons rather than from a carry chain. A seeded operand sweep across all eight selector values adds further cases of the same kind.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_ADC  = 3'b001,
    OP_SUB  = 3'b010,
    OP_SBC  = 3'b011,
    OP_RSB  = 3'b100,
    OP_RSC  = 3'b101,
    OP_RSV6 = 3'b110,
    OP_RSV7 = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  localparam int FLAG_BITS = $bits(alu_flags_t);

endpackage

// File: rtl/alu_opnd_steer.sv
module alu_opnd_steer
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         carry_in,
  output logic [W-1:0] add_x,
  output logic [W-1:0] add_y,
  output logic         add_cin,
  output logic         op_valid
);

  alu_op_e op;
  logic    swap;
  logic    invert;
  logic    use_cin;
  logic    fixed_cin;

  assign op = alu_op_e'(op_sel);

  always_comb begin
    swap      = 1'b0;
    invert    = 1'b0;
    use_cin   = 1'b0;
    fixed_cin = 1'b0;
    op_valid  = 1'b1;
    unique case (op)
      OP_ADD: ;
      OP_ADC: use_cin = 1'b1;
      OP_SUB: begin invert = 1'b1; fixed_cin = 1'b1; end
      OP_SBC: begin invert = 1'b1; use_cin = 1'b1; end
      OP_RSB: begin swap = 1'b1; invert = 1'b1; fixed_cin = 1'b1; end
      OP_RSC: begin swap = 1'b1; invert = 1'b1; use_cin = 1'b1; end
      default: op_valid = 1'b0;
    endcase
  end

  logic [W-1:0] first_in;
  logic [W-1:0] second_in;

  assign first_in  = swap ? opnd_b : opnd_a;
  assign second_in = swap ? opnd_a : opnd_b;
  assign add_x     = first_in;
  assign add_y     = invert ? ~second_in : second_in;
  assign add_cin   = use_cin ? carry_in : fixed_cin;

endmodule

// File: rtl/alu_adder_core.sv
module alu_adder_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  localparam int WX = W + 1;

  logic [WX-1:0] wide;

  assign wide = {1'b0, x} + {1'b0, y} + WX'(cin);
  assign sum  = wide[W-1:0];
  assign cout = wide[W];

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] sum,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cout,
  output alu_flags_t   flags
);

  localparam int MSB = W - 1;

  logic same_sign_in;
  logic sign_flip;

  assign same_sign_in = ~(x[MSB] ^ y[MSB]);
  assign sign_flip    = x[MSB] ^ sum[MSB];

  assign flags.n = sum[MSB];
  assign flags.z = ~|sum;
  assign flags.c = cout;
  assign flags.v = same_sign_in & sign_flip;

endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage #(
  parameter int W       = 32,
  parameter int FW      = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  res_d,
  input  logic [FW-1:0] flg_d,
  input  logic          we_d,
  output logic [W-1:0]  res_q,
  output logic [FW-1:0] flg_q,
  output logic          we_q
);

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          res_q <= '0;
          flg_q <= '0;
          we_q  <= 1'b0;
        end else begin
          res_q <= res_d;
          flg_q <= flg_d;
          we_q  <= we_d;
        end
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst;
      assign res_q = res_d;
      assign flg_q = flg_d;
      assign we_q  = we_d;
    end
  endgenerate

endmodule

// File: rtl/addsub_flag_alu.sv
module addsub_flag_alu
  import alu_pkg::*;
#(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           op_sel,
  input  logic [W-1:0]         opnd_a,
  input  logic [W-1:0]         opnd_b,
  input  logic                 carry_in,
  input  logic [FLAG_BITS-1:0] flags_in,
  input  logic                 set_flags,
  output logic [W-1:0]         result,
  output logic [FLAG_BITS-1:0] flags_out,
  output logic                 flags_we
);

  logic [W-1:0] add_x;
  logic [W-1:0] add_y;
  logic         add_cin;
  logic         op_valid;
  logic [W-1:0] sum;
  logic         cout;
  alu_flags_t   flg_calc;

  alu_opnd_steer #(.W(W)) u_steer (
    .op_sel   (op_sel),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .carry_in (carry_in),
    .add_x    (add_x),
    .add_y    (add_y),
    .add_cin  (add_cin),
    .op_valid (op_valid)
  );

  alu_adder_core #(.W(W)) u_adder (
    .x    (add_x),
    .y    (add_y),
    .cin  (add_cin),
    .sum  (sum),
    .cout (cout)
  );

  alu_flag_gen #(.W(W)) u_flags (
    .sum   (sum),
    .x     (add_x),
    .y     (add_y),
    .cout  (cout),
    .flags (flg_calc)
  );

  logic                 upd;
  logic [W-1:0]         res_nxt;
  logic [FLAG_BITS-1:0] flg_nxt;

  assign upd     = op_valid & set_flags;
  assign res_nxt = op_valid ? sum : opnd_a;
  assign flg_nxt = upd ? flg_calc : flags_in;

  alu_out_stage #(.W(W), .FW(FLAG_BITS), .OUT_REG(OUT_REG)) u_out (
    .clk   (clk),
    .rst   (rst),
    .res_d (res_nxt),
    .flg_d (flg_nxt),
    .we_d  (upd),
    .res_q (result),
    .flg_q (flags_out),
    .we_q  (flags_we)
  );

  p_add_carry_r1: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ADD) |-> (flg_calc.c == (sum < opnd_a)));

  p_adc_carry_r2: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ADC && carry_in) |-> (flg_calc.c == (sum <= opnd_a)));

  p_sub_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SUB) |-> (flg_calc.c == (opnd_a >= opnd_b)));

  p_sbc_carry_r4: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SBC && !carry_in) |-> (flg_calc.c == (opnd_a > opnd_b)));

  p_rsb_carry_r5: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_RSB) |-> (flg_calc.c == (opnd_b >= opnd_a)));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
    flg_calc.z == (sum == '0));

  generate
    if (OUT_REG) begin : g_reg_chk
      p_hold_flags_r9: assert property (@(posedge clk) disable iff (rst)
        !set_flags |=> (flags_out == $past(flags_in) && !flags_we));

      p_passthru_r8: assert property (@(posedge clk) disable iff (rst)
        (op_sel[2:1] == 2'b11) |=> (result == $past(opnd_a) && !flags_we));
    end
  endgenerate

endmodule

// File: tb/test_addsub_flag_alu.sv
module test_addsub_flag_alu;

  localparam int W       = 32;
  localparam int CLK_PER = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    op_sel;
  logic [W-1:0]  opnd_a;
  logic [W-1:0]  opnd_b;
  logic          carry_in;
  logic [3:0]    flags_in;
  logic          set_flags;
  logic [W-1:0]  result;
  logic [3:0]    flags_out;
  logic          flags_we;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  addsub_flag_alu #(.W(W), .OUT_REG(1'b1)) i_addsub_flag_alu (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .carry_in(carry_in), .flags_in(flags_in), .set_flags(set_flags),
    .result(result), .flags_out(flags_out), .flags_we(flags_we)
  );

  // Reference built from compares, per the requirements.
  task automatic model(input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic ci,
                       input logic [3:0] fin, input logic sf,
                       output logic [W-1:0] r, output logic [3:0] f,
                       output logic we);
    logic [W-1:0] m, s;
    logic c, v;
    r = a; c = 1'b0; v = 1'b0;
    if (op == 3'd0 || op == 3'd1) begin
      if (op == 3'd1 && ci) begin r = a + b + 1; c = (r <= a); end
      else begin r = a + b; c = (r < a); end
      v = ~(a[W-1] ^ b[W-1]) & (a[W-1] ^ r[W-1]);
    end else if (op <= 3'd5) begin
      m = (op >= 3'd4) ? b : a;
      s = (op >= 3'd4) ? a : b;
      if ((op == 3'd3 || op == 3'd5) && !ci) begin r = m - s - 1; c = (m > s); end
      else begin r = m - s; c = (m >= s); end
      v = (m[W-1] ^ s[W-1]) & (m[W-1] ^ r[W-1]);
    end
    if (op <= 3'd5 && sf) begin
      f  = {r[W-1], (r == '0), c, v};
      we = 1'b1;
    end else begin
      f  = fin;
      we = 1'b0;
    end
  endtask

  task automatic run_op(input string req, input logic [2:0] op,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic ci, input logic [3:0] fin, input logic sf);
    logic [W-1:0] er;
    logic [3:0]   ef;
    logic         ew;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; carry_in = ci;
    flags_in = fin; set_flags = sf;
    model(op, a, b, ci, fin, sf, er, ef, ew);
    @(negedge clk);
    checks++;
    if (result !== er || flags_out !== ef || flags_we !== ew) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h ci=%0b: got res=%h flg=%b we=%b exp res=%h flg=%b we=%b",
               req, op, a, b, ci, result, flags_out, flags_we, er, ef, ew);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; op_sel = 3'd0; opnd_a = 32'hDEAD_BEEF; opnd_b = 32'h1;
    carry_in = 1'b1; flags_in = 4'hF; set_flags = 1'b1;
    @(negedge clk);
    checks++;
    if (result !== '0 || flags_out !== 4'h0 || flags_we !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: got res=%h flg=%b we=%b exp res=0 flg=0000 we=0",
               result, flags_out, flags_we);
    end
    rst = 1'b0;
  endtask

  task automatic t_add;
    run_op("R1", 3'd0, 32'h0000_0003, 32'h0000_0004, 1'b1, 4'h0, 1'b1);
    run_op("R1", 3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 4'h0, 1'b1);
    run_op("R6", 3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 4'h0, 1'b1);
    run_op("R6", 3'd0, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'h0, 1'b1);
  endtask

  task automatic t_adc;
    run_op("R2", 3'd1, 32'h0000_0005, 32'hFFFF_FFFF, 1'b1, 4'h0, 1'b1);
    run_op("R2", 3'd1, 32'h0000_0005, 32'hFFFF_FFFF, 1'b0, 4'h0, 1'b1);
    run_op("R2", 3'd1, 32'h1234_0000, 32'h0000_5678, 1'b1, 4'h0, 1'b1);
  endtask

  task automatic t_sub;
    run_op("R3", 3'd2, 32'h0000_0010, 32'h0000_0010, 1'b0, 4'h0, 1'b1);
    run_op("R3", 3'd2, 32'h0000_0001, 32'h0000_0002, 1'b1, 4'h0, 1'b1);
    run_op("R6", 3'd2, 32'h8000_0000, 32'h0000_0001, 1'b0, 4'h0, 1'b1);
    run_op("R4", 3'd3, 32'h0000_0010, 32'h0000_0010, 1'b0, 4'h0, 1'b1);
    run_op("R4", 3'd3, 32'h0000_0010, 32'h0000_0010, 1'b1, 4'h0, 1'b1);
    run_op("R4", 3'd3, 32'h0000_0011, 32'h0000_0010, 1'b0, 4'h0, 1'b1);
  endtask

  task automatic t_reverse;
    run_op("R5", 3'd4, 32'h0000_0002, 32'h0000_0009, 1'b0, 4'h0, 1'b1);
    run_op("R5", 3'd4, 32'h0000_0009, 32'h0000_0002, 1'b1, 4'h0, 1'b1);
    run_op("R5", 3'd5, 32'h0000_0007, 32'h0000_0007, 1'b0, 4'h0, 1'b1);
    run_op("R5", 3'd5, 32'h0000_0007, 32'h0000_0007, 1'b1, 4'h0, 1'b1);
  endtask

  task automatic t_gating;
    run_op("R9", 3'd0, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'b1010, 1'b0);
    run_op("R9", 3'd2, 32'h0000_0001, 32'h0000_0005, 1'b1, 4'b0101, 1'b0);
    run_op("R8", 3'd6, 32'hCAFE_F00D, 32'h1111_1111, 1'b1, 4'b0110, 1'b1);
    run_op("R8", 3'd7, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 4'b1001, 1'b1);
    run_op("R7", 3'd2, 32'h0000_0000, 32'h0000_0001, 1'b1, 4'h0, 1'b1);
  endtask

  task automatic t_sweep;
    logic [31:0] seed = 32'h1357_9BDF;
    for (int i = 0; i < 64; i++) begin
      logic [W-1:0] a, b;
      seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; b = (i % 5 == 0) ? a : seed;
      run_op("R6", 3'(i % 8), a, b, seed[7], seed[11:8], (i % 7 != 3));
    end
  endtask

  initial begin
    rst = 1'b1; op_sel = '0; opnd_a = '0; opnd_b = '0;
    carry_in = 1'b0; flags_in = '0; set_flags = 1'b0;
    t_reset();
    t_add();
    t_adc();
    t_sub();
    t_reverse();
    t_gating();
    t_sweep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule